// File: doc/BRIEF.md
# CAN Receive Queue with Foreground Buffer

This block sits behind a CAN receiver front end and holds frames that have already passed identifier acceptance and CRC checks. Frames are pushed into a small first-in first-out queue. The oldest queued frame moves into a single foreground slot, and a buffer-full flag is raised. A CPU reads the foreground frame directly and then releases the slot by writing one to that flag.

While the flag stays set, the queue is frozen at its output. No later frame can overwrite the slot the CPU is reading. Once the flag clears, the next frame is loaded on the following clock. If a frame arrives when every queue entry is occupied, the frame is dropped and a sticky overrun flag is set. Both flags can raise an interrupt, and each interrupt has its own enable bit.

The register interface has two addresses. Address 0 holds the flags, and writing one to a flag clears it. Address 1 holds the interrupt enables. Reads return the register selected by the current address within the same cycle.

Top module: `rxq_foreground`

## Requirements
- R1: After reset, both flags and both enable bits are 0, both interrupts are low, and reads at addresses 0 and 1 return 0.
- R2: A frame pushed with `push_ok`=1 into an empty block reaches `fg_frame` two clock edges after its push cycle. At that edge the buffer-full flag (address 0, bit 0) becomes 1.
- R3: A push with `push_ok`=0 is discarded: it never enters the queue and never reaches the foreground slot.
- R4: While the buffer-full flag is set and not being cleared, `fg_frame` and the flag hold their values, even when frames are waiting in the queue.
- R5: Writing 1 to address 0 bit 0 clears the buffer-full flag at the next edge. If the queue is not empty, the next frame is loaded and the flag is set again one edge later.
- R6: Frames leave the queue in the order they were accepted.
- R7: `rx_irq` is high exactly while the buffer-full flag is 1 and enable bit 0 (address 1) is 1.
- R8: An accepted push when all DEPTH queue entries are occupied, and no entry moves to the foreground in that cycle, drops the frame and sets the sticky overrun flag (address 0, bit 1).
- R9: `ovr_irq` is high exactly while the overrun flag and enable bit 1 are both 1. Writing 1 to address 0 bit 1 clears the overrun flag.
- R10: Writing 0 to a flag bit leaves it unchanged. A write-one clear in the same cycle as that flag's set event leaves the flag at 1.
- R11: A write to address 1 stores bits [1:0] as the enables. Reads of address 1 return them in bits [1:0], with zeros above. Addresses 2 and 3 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Front end presents a frame this cycle |
| push_ok | input | 1 | The presented frame was received without error |
| push_frame | input | FRAME_W | Frame contents |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| fg_frame | output | FRAME_W | Frame in the foreground slot |
| rx_irq | output | 1 | Receive interrupt |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
Two events can meet in one cycle: the CPU's write-one clear of the overrun flag, and a push into a full queue that sets that same flag. The bench fills the queue behind a held foreground frame, then issues the clear and the overflowing push together. It expects the flag to read back as 1, and to fall only after a later clear that arrives alone. In the same way, a release of the buffer-full flag can land in the cycle where a reload sets it. Random traffic is compared cycle by cycle against a bench model that applies the set-wins rule, so such collisions are judged on every occurrence.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        REG_FLAGS  = 2'd0,
        REG_ENABLE = 2'd1
    } reg_sel_e;

    localparam int REG_W        = 8;
    localparam int FLAG_FULL    = 0;
    localparam int FLAG_OVR     = 1;
    localparam int EN_RX        = 0;
    localparam int EN_OVR       = 1;
    localparam int EN_W         = 2;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int FRAME_W = 80,
    parameter int DEPTH   = 4,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_en,
    input  logic               pop_en,
    input  logic [FRAME_W-1:0] push_frame,
    output logic [FRAME_W-1:0] head_frame,
    output logic [CNT_W-1:0]   level,
    output logic               at_cap,
    output logic               is_empty
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] level;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    logic [FRAME_W-1:0] slot_d [DEPTH];
    logic [FRAME_W-1:0] slot_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_en) begin
            st_d.wr_ptr = bump(st_q.wr_ptr);
        end
        if (pop_en) begin
            st_d.rd_ptr = bump(st_q.rd_ptr);
        end
        case ({push_en, pop_en})
            2'b10:   st_d.level = st_q.level + CNT_W'(1);
            2'b01:   st_d.level = st_q.level - CNT_W'(1);
            default: st_d.level = st_q.level;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (push_en && (st_q.wr_ptr == PTR_W'(g))) begin
                slot_d[g] = push_frame;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end
    end

    assign head_frame = slot_q[st_q.rd_ptr];
    assign level      = st_q.level;
    assign at_cap     = (st_q.level == CNT_W'(DEPTH));
    assign is_empty   = (st_q.level == '0);

endmodule

// File: rtl/rxq_fg_ctrl.sv
module rxq_fg_ctrl #(
    parameter int FRAME_W = 80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q_empty,
    input  logic [FRAME_W-1:0] head_frame,
    input  logic               release_req,
    output logic               pop,
    output logic [FRAME_W-1:0] fg_frame,
    output logic               fg_full
);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               full;
    } fg_state_t;

    fg_state_t fg_d, fg_q;
    logic      load;

    always_comb begin
        fg_d = fg_q;
        load = !fg_q.full && !q_empty;
        if (load) begin
            fg_d.frame = head_frame;
            fg_d.full  = 1'b1;
        end else if (release_req) begin
            fg_d.full  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fg_q <= '0;
        end else begin
            fg_q <= fg_d;
        end
    end

    assign pop      = load;
    assign fg_frame = fg_q.frame;
    assign fg_full  = fg_q.full;

endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             fg_full,
    input  logic             ovr_set,
    output logic             release_fg,
    output logic             ovr_flag,
    output logic [EN_W-1:0]  en_bits,
    output logic             rx_irq,
    output logic             ovr_irq,
    output logic [REG_W-1:0] rd_data
);

    typedef struct packed {
        logic            ovr;
        logic [EN_W-1:0] en;
    } reg_state_t;

    reg_state_t rs_d, rs_q;
    logic       flag_wr;
    logic       en_wr;
    logic       unused_wbits;

    assign flag_wr      = wr_en && (addr == REG_FLAGS);
    assign en_wr        = wr_en && (addr == REG_ENABLE);
    assign unused_wbits = ^wr_data[REG_W-1:EN_W];

    always_comb begin
        rs_d = rs_q;
        if (ovr_set) begin
            rs_d.ovr = 1'b1;
        end else if (flag_wr && wr_data[FLAG_OVR]) begin
            rs_d.ovr = 1'b0;
        end
        if (en_wr) begin
            rs_d.en = wr_data[EN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            REG_FLAGS: begin
                rd_data[FLAG_FULL] = fg_full;
                rd_data[FLAG_OVR]  = rs_q.ovr;
            end
            REG_ENABLE: begin
                rd_data[EN_W-1:0] = rs_q.en;
            end
            default: rd_data = '0;
        endcase
    end

    assign release_fg = flag_wr && wr_data[FLAG_FULL];
    assign ovr_flag   = rs_q.ovr;
    assign en_bits    = rs_q.en;
    assign rx_irq     = fg_full  && rs_q.en[EN_RX];
    assign ovr_irq    = rs_q.ovr && rs_q.en[EN_OVR];

endmodule

// File: rtl/rxq_foreground.sv
module rxq_foreground
    import rxq_pkg::*;
#(
    parameter int FRAME_W = 80,
    parameter int DEPTH   = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_valid,
    input  logic               push_ok,
    input  logic [FRAME_W-1:0] push_frame,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [FRAME_W-1:0] fg_frame,
    output logic               rx_irq,
    output logic               ovr_irq
);

    logic               accept;
    logic               ovr_set;
    logic               push_en;
    logic               pop;
    logic               q_empty;
    logic               q_at_cap;
    logic [CNT_W-1:0]   q_level;
    logic [FRAME_W-1:0] head_frame;
    logic               release_fg;
    logic               fg_full;
    logic               ovr_flag;
    logic [EN_W-1:0]    en_bits;

    assign accept  = push_valid && push_ok;
    assign ovr_set = accept && q_at_cap && !pop;
    assign push_en = accept && !ovr_set;

    rxq_store #(
        .FRAME_W (FRAME_W),
        .DEPTH   (DEPTH)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_en    (push_en),
        .pop_en     (pop),
        .push_frame (push_frame),
        .head_frame (head_frame),
        .level      (q_level),
        .at_cap     (q_at_cap),
        .is_empty   (q_empty)
    );

    rxq_fg_ctrl #(
        .FRAME_W (FRAME_W)
    ) fg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_empty     (q_empty),
        .head_frame  (head_frame),
        .release_req (release_fg),
        .pop         (pop),
        .fg_frame    (fg_frame),
        .fg_full     (fg_full)
    );

    rxq_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wr_data    (reg_wdata),
        .fg_full    (fg_full),
        .ovr_set    (ovr_set),
        .release_fg (release_fg),
        .ovr_flag   (ovr_flag),
        .en_bits    (en_bits),
        .rx_irq     (rx_irq),
        .ovr_irq    (ovr_irq),
        .rd_data    (reg_rdata)
    );

endmodule

// File: rtl/rxq_fg_checker.sv
module rxq_fg_checker #(
    parameter int FRAME_W = 80,
    parameter int DEPTH   = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               push_valid,
    input logic               push_ok,
    input logic               reg_wr,
    input logic [1:0]         reg_addr,
    input logic [7:0]         reg_wdata,
    input logic [FRAME_W-1:0] fg_frame,
    input logic               fg_full,
    input logic               ovr_flag,
    input logic [1:0]         en_bits,
    input logic               rx_irq,
    input logic               ovr_irq,
    input logic [CNT_W-1:0]   q_level
);

    logic clr_full_wr;
    logic clr_ovr_wr;

    assign clr_full_wr = reg_wr && (reg_addr == 2'd0) && reg_wdata[0];
    assign clr_ovr_wr  = reg_wr && (reg_addr == 2'd0) && reg_wdata[1];

    assert_bad_frame_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ok && fg_full) |=> $stable(q_level));

    assert_hold_while_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fg_full && !clr_full_wr) |=> (fg_full && $stable(fg_frame)));

    assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fg_full && clr_full_wr) |=> !fg_full);

    assert_reload_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fg_full && (q_level != '0)) |=> fg_full);

    assert_rx_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == (fg_full && en_bits[0]));

    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ok && (q_level == CNT_W'(DEPTH)) && fg_full) |=> ovr_flag);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !clr_ovr_wr) |=> ovr_flag);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= CNT_W'(DEPTH));

    assert_ovr_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_irq == (ovr_flag && en_bits[1]));

    assert_write_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 2'd0) && (reg_wdata[1:0] == 2'b00) && fg_full) |=> fg_full);

endmodule

bind rxq_foreground rxq_fg_checker #(
    .FRAME_W (FRAME_W),
    .DEPTH   (DEPTH)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_ok    (push_ok),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .fg_frame   (fg_frame),
    .fg_full    (fg_full),
    .ovr_flag   (ovr_flag),
    .en_bits    (en_bits),
    .rx_irq     (rx_irq),
    .ovr_irq    (ovr_irq),
    .q_level    (q_level)
);

// File: tb/rxq_foreground_tb_top.sv
module rxq_foreground_tb_top;

    localparam int FW    = 80;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_valid = 1'b0;
    logic          push_ok = 1'b0;
    logic [FW-1:0] push_frame = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [7:0]    reg_wdata = 8'd0;
    logic [7:0]    reg_rdata;
    logic [FW-1:0] fg_frame;
    logic          rx_irq;
    logic          ovr_irq;

    always #10 clk = ~clk;

    rxq_foreground #(.FRAME_W(FW), .DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_ok    (push_ok),
        .push_frame (push_frame),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .fg_frame   (fg_frame),
        .rx_irq     (rx_irq),
        .ovr_irq    (ovr_irq)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    logic [FW-1:0] mq [DEPTH];
    int            mcount = 0;
    logic [FW-1:0] mfg = '0;
    bit            mfull = 1'b0;
    bit            movr = 1'b0;
    logic [1:0]    men = 2'b00;

    task automatic chk(input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return {6'b0, movr, mfull};
            2'd1:    return {6'b0, men};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step();
        bit pop;
        bit acc;
        bit fw;
        bit ovf;
        pop = !mfull && (mcount > 0);
        acc = push_valid && push_ok;
        fw  = reg_wr && (reg_addr == 2'd0);
        ovf = acc && (mcount == DEPTH) && !pop;
        if (pop) begin
            mfg = mq[0];
            for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i + 1];
            mcount--;
            mfull = 1'b1;
        end else if (fw && reg_wdata[0]) begin
            mfull = 1'b0;
        end
        if (acc && !ovf) begin
            mq[mcount] = push_frame;
            mcount++;
        end
        if (ovf) movr = 1'b1;
        else if (fw && reg_wdata[1]) movr = 1'b0;
        if (reg_wr && (reg_addr == 2'd1)) men = reg_wdata[1:0];
    endtask

    task automatic compare_all();
        chk((reg_addr == 2'd1) ? "R11" : "R5", "reg_rdata", reg_rdata, exp_rdata(reg_addr));
        chk("R6", "fg_frame", fg_frame, mfg);
        chk("R7", "rx_irq", rx_irq, mfull && men[0]);
        chk("R9", "ovr_irq", ovr_irq, movr && men[1]);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive(input bit pv, input bit pok, input logic [FW-1:0] fr,
                         input bit wr, input logic [1:0] a, input logic [7:0] wd);
        push_valid = pv;
        push_ok    = pok;
        push_frame = fr;
        reg_wr     = wr;
        reg_addr   = a;
        reg_wdata  = wd;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, '0, 1'b0, 2'd0, 8'h00);
    endtask

    function automatic logic [FW-1:0] rnd_frame();
        return FW'({$urandom(), $urandom(), $urandom()});
    endfunction

    initial begin
        logic [FW-1:0] fa, fb, fc;
        void'($urandom(32'h5EED_0C4A));
        fa = rnd_frame();
        fb = rnd_frame();
        fc = rnd_frame();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", "flags after reset", reg_rdata, 8'h00);
        chk("R1", "rx_irq after reset", rx_irq, 1'b0);
        chk("R1", "ovr_irq after reset", ovr_irq, 1'b0);
        reg_addr = 2'd1;
        #1;
        chk("R1", "enables after reset", reg_rdata, 8'h00);

        // R11: enables written and read back
        drive(1'b0, 1'b0, '0, 1'b1, 2'd1, 8'hFF);
        cycle();
        idle();
        reg_addr = 2'd1;
        #1;
        chk("R11", "enable readback", reg_rdata, 8'h03);
        drive(1'b0, 1'b0, '0, 1'b1, 2'd2, 8'hFF);
        cycle();
        chk("R11", "address 2 reads zero", reg_rdata, 8'h00);
        idle();

        // R2: first frame appears two edges after push
        drive(1'b1, 1'b1, fa, 1'b0, 2'd0, 8'h00);
        cycle();
        idle();
        chk("R2", "flag one edge after push", reg_rdata[0], 1'b0);
        cycle();
        chk("R2", "flag two edges after push", reg_rdata[0], 1'b1);
        chk("R2", "foreground frame", fg_frame, fa);
        chk("R7", "rx_irq with enable", rx_irq, 1'b1);

        // R3: bad frame discarded
        drive(1'b1, 1'b0, rnd_frame(), 1'b0, 2'd0, 8'h00);
        cycle();
        drive(1'b0, 1'b0, '0, 1'b1, 2'd0, 8'h01);
        cycle();
        idle();
        cycle();
        cycle();
        chk("R3", "no load after bad push", reg_rdata[0], 1'b0);
        chk("R3", "foreground unchanged", fg_frame, fa);

        // R4: hold while flag set
        drive(1'b1, 1'b1, fb, 1'b0, 2'd0, 8'h00);
        cycle();
        drive(1'b1, 1'b1, fc, 1'b0, 2'd0, 8'h00);
        cycle();
        idle();
        repeat (4) cycle();
        chk("R4", "foreground held", fg_frame, fb);
        chk("R4", "flag held", reg_rdata[0], 1'b1);

        // R10: writing zero leaves the flag
        drive(1'b0, 1'b0, '0, 1'b1, 2'd0, 8'h00);
        cycle();
        idle();
        chk("R10", "write zero keeps flag", reg_rdata[0], 1'b1);

        // R5: release and reload
        drive(1'b0, 1'b0, '0, 1'b1, 2'd0, 8'h01);
        cycle();
        idle();
        chk("R5", "flag clear after release", reg_rdata[0], 1'b0);
        cycle();
        chk("R5", "flag set again", reg_rdata[0], 1'b1);
        chk("R6", "next frame in order", fg_frame, fc);

        // R8: fill queue then overflow
        for (int i = 0; i < DEPTH; i++) begin
            drive(1'b1, 1'b1, rnd_frame(), 1'b0, 2'd0, 8'h00);
            cycle();
        end
        chk("R8", "no overrun at capacity", reg_rdata[1], 1'b0);
        drive(1'b1, 1'b1, rnd_frame(), 1'b0, 2'd0, 8'h00);
        cycle();
        chk("R8", "overrun set", reg_rdata[1], 1'b1);
        chk("R9", "ovr_irq with enable", ovr_irq, 1'b1);

        // R10: clear collides with new overrun
        drive(1'b1, 1'b1, rnd_frame(), 1'b1, 2'd0, 8'h02);
        cycle();
        chk("R10", "overrun set wins over clear", reg_rdata[1], 1'b1);
        drive(1'b0, 1'b0, '0, 1'b1, 2'd0, 8'h02);
        cycle();
        idle();
        chk("R9", "overrun cleared", reg_rdata[1], 1'b0);
        chk("R9", "ovr_irq low", ovr_irq, 1'b0);

        // drain in order (model checks R6)
        for (int i = 0; i < DEPTH + 1; i++) begin
            drive(1'b0, 1'b0, '0, 1'b1, 2'd0, 8'h01);
            cycle();
            idle();
            cycle();
        end

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            drive(1'($urandom() % 2), 1'(($urandom() % 4) != 0), rnd_frame(),
                  1'(($urandom() % 6) == 0), 2'($urandom() % 4), 8'($urandom()));
            cycle();
        end
        idle();
        cycle();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule